// File: doc/BRIEF.md
# Parallel Configuration Loader

This block loads a configuration image into a programmable target device through that device's 16-bit parallel slave port. A single `start` pulse launches a fixed sequence. The block selects the port for writing and resets the target with a long pulse on the program line. It then waits until the target reports that it is ready. After that it moves payload words from a valid/ready stream onto the data bus, one configuration-clock pulse per word. It checks the target's init line for a configuration error, waits a bounded time for the done line, and finishes with eight extra configuration clocks so the target can complete its startup.

The payload arrives on `s_data` with `s_valid`/`s_ready` flow control. `s_last` marks the final word. Header parsing and pad-level synchronisation are done elsewhere. The init and done inputs pass through two-flop synchronisers inside the block. While a load runs, `busy` is high. At the end exactly one of `ok` and `err` is set, and it stays set until the next accepted `start`.

The reset pulse length and the done timeout are parameters counted in clock cycles. The transfer width is a parameter. Only two bytes per transfer is supported, and any other value makes `start` fail at once, before any pin moves.

Top module: `cfg_loader`

## Requirements
- R1: After reset and while idle: `cfg_prog_n`=1, `cfg_sel_n`=1, `cfg_wr_n`=1, `cfg_cclk`=0, `s_ready`=0, and `busy`, `ok`, `err` are all 0.
- R2: A `start` sampled while idle begins with one cycle in which `cfg_prog_n`=1 and `cfg_sel_n`=`cfg_wr_n`=0. Then `cfg_prog_n` is held low for exactly RST_CYCLES cycles and returns high.
- R3: After the reset pulse, `s_ready` stays 0 and `cfg_cclk` does not pulse until `cfg_init` has been seen high through the two-flop synchroniser.
- R4: Each accepted word appears on `cfg_d` one cycle before a rising edge of `cfg_cclk` and holds through that edge. There is exactly one rising edge per word, and words go out in stream order.
- R5: The word accepted with `s_last`=1 ends the transfer. If the synchronised `cfg_init` then reads 0, the load ends with `err`=1 and no further `cfg_cclk` pulses.
- R6: If the synchronised `cfg_done` stays 0 for DONE_TIMEOUT cycles after the transfer check, the load ends with `err`=1 and no trailing clocks.
- R7: Once the synchronised `cfg_done` reads 1, exactly eight further `cfg_cclk` pulses are issued. The load then ends with `ok`=1.
- R8: When BUS_BYTES is not 2, `start` sets `err`=1 within two cycles. `cfg_prog_n`, `cfg_sel_n`, `cfg_wr_n`, `cfg_cclk` and `s_ready` keep their idle values.
- R9: A `start` pulse while `busy`=1 is ignored, and no second reset pulse occurs.
- R10: `ok` and `err` are never both 1. Both are cleared by an accepted `start` and stay 0 while the load runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that launches a load |
| s_data | input | 8*BUS_BYTES | Payload word |
| s_valid | input | 1 | Payload word valid |
| s_last | input | 1 | Marks the final payload word |
| s_ready | output | 1 | Block accepts a payload word |
| cfg_prog_n | output | 1 | Target program/reset line, active low |
| cfg_sel_n | output | 1 | Target port select, active low |
| cfg_wr_n | output | 1 | Target direction, 0 = write |
| cfg_cclk | output | 1 | Configuration clock |
| cfg_d | output | 8*BUS_BYTES | Configuration data bus |
| cfg_init | input | 1 | Target init status (high = ready / no error) |
| cfg_done | input | 1 | Target done status |
| busy | output | 1 | Load in progress |
| ok | output | 1 | Last load succeeded |
| err | output | 1 | Last load failed |

## Verification
The main instance is built with RST_CYCLES=20 and DONE_TIMEOUT=50. With these values the bench can count the whole reset pulse and run a full done timeout within a few hundred cycles, so the length of both windows is checked exactly. A second instance uses BUS_BYTES=4. That makes the unsupported-width rejection reachable, and the bench watches it alongside the normal instance.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int BUS_BYTES    = 2,
  parameter int RST_CYCLES   = 2000000,
  parameter int DONE_TIMEOUT = 100000,
  parameter int TRAIL_CLKS   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [8*BUS_BYTES-1:0] s_data,
  input  logic                   s_valid,
  input  logic                   s_last,
  output logic                   s_ready,
  output logic                   cfg_prog_n,
  output logic                   cfg_sel_n,
  output logic                   cfg_wr_n,
  output logic                   cfg_cclk,
  output logic [8*BUS_BYTES-1:0] cfg_d,
  input  logic                   cfg_init,
  input  logic                   cfg_done,
  output logic                   busy,
  output logic                   ok,
  output logic                   err
);
  localparam int DW       = 8 * BUS_BYTES;
  localparam bit WIDTH_OK = (BUS_BYTES == 2);
  localparam int CMAX     = (RST_CYCLES > DONE_TIMEOUT) ?
                            ((RST_CYCLES > 2*TRAIL_CLKS) ? RST_CYCLES : 2*TRAIL_CLKS) :
                            ((DONE_TIMEOUT > 2*TRAIL_CLKS) ? DONE_TIMEOUT : 2*TRAIL_CLKS);
  localparam int CW       = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_PULSE, S_WINIT, S_DLO, S_DHI, S_CHK, S_WDONE, S_TRAIL
  } state_t;

  state_t        st;
  logic [CW-1:0] cnt;
  logic [DW-1:0] d_q;
  logic          cclk_q, last_q, ok_q, err_q;
  logic [1:0]    init_sy, done_sy;

  wire init_s = init_sy[1];
  wire done_s = done_sy[1];

  assign cfg_prog_n = (st != S_PULSE);
  assign cfg_sel_n  = (st == S_IDLE);
  assign cfg_wr_n   = (st == S_IDLE);
  assign cfg_cclk   = cclk_q;
  assign cfg_d      = d_q;
  assign s_ready    = (st == S_DLO);
  assign busy       = (st != S_IDLE);
  assign ok         = ok_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_sy <= '0;
      done_sy <= '0;
    end else begin
      init_sy <= {init_sy[0], cfg_init};
      done_sy <= {done_sy[0], cfg_done};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      d_q    <= '0;
      cclk_q <= 1'b0;
      last_q <= 1'b0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          cclk_q <= 1'b0;
          if (start) begin
            ok_q  <= 1'b0;
            err_q <= !WIDTH_OK;
            if (WIDTH_OK) st <= S_SETUP;
          end
        end
        S_SETUP: begin
          cnt <= '0;
          st  <= S_PULSE;
        end
        S_PULSE: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(RST_CYCLES - 1)) st <= S_WINIT;
        end
        S_WINIT: if (init_s) st <= S_DLO;
        S_DLO: begin
          cclk_q <= 1'b0;
          if (s_valid) begin
            d_q    <= s_data;
            last_q <= s_last;
            st     <= S_DHI;
          end
        end
        S_DHI: begin
          cclk_q <= 1'b1;
          st     <= last_q ? S_CHK : S_DLO;
        end
        S_CHK: begin
          cclk_q <= 1'b0;
          cnt    <= '0;
          if (!init_s) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            st <= S_WDONE;
          end
        end
        S_WDONE: begin
          if (done_s) begin
            cnt <= '0;
            st  <= S_TRAIL;
          end else if (cnt == CW'(DONE_TIMEOUT - 1)) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_TRAIL: begin
          cclk_q <= ~cclk_q;
          cnt    <= cnt + 1'b1;
          if (cnt == CW'(2*TRAIL_CLKS - 1)) begin
            ok_q <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int BUS_BYTES  = 2,
  parameter int RST_CYCLES = 2000000
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_prog_n,
  input logic                   cfg_sel_n,
  input logic                   cfg_cclk,
  input logic [8*BUS_BYTES-1:0] cfg_d,
  input logic                   cfg_init,
  input logic                   s_ready,
  input logic                   busy,
  input logic                   ok,
  input logic                   err
);
  int unsigned low_run;
  logic [1:0]  isy;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run <= 0;
      isy     <= '0;
      seen    <= 1'b0;
    end else begin
      low_run <= cfg_prog_n ? 0 : low_run + 1;
      isy     <= {isy[0], cfg_init};
      if (!cfg_prog_n)      seen <= 1'b0;
      else if (isy[1])      seen <= 1'b1;
    end
  end

  assert_pulse_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_prog_n |-> low_run < RST_CYCLES);
  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_prog_n) |-> low_run == RST_CYCLES);
  assert_wait_init_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> seen);
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_cclk) |-> $stable(cfg_d));
  assert_ready_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> busy);
  assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && err));
  assert_quiet_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !ok && !err);

  generate
    if (BUS_BYTES != 2) begin : g_bad
      assert_bad_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prog_n && cfg_sel_n && !cfg_cclk && !s_ready);
    end
  endgenerate
endmodule

bind cfg_loader cfg_loader_chk #(.BUS_BYTES(BUS_BYTES), .RST_CYCLES(RST_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_prog_n(cfg_prog_n), .cfg_sel_n(cfg_sel_n),
  .cfg_cclk(cfg_cclk), .cfg_d(cfg_d), .cfg_init(cfg_init), .s_ready(s_ready),
  .busy(busy), .ok(ok), .err(err)
);

// File: tb/tb_cfg_loader.sv
module tb_cfg_loader;
  localparam int RSTC = 20;
  localparam int TMO  = 50;

  logic clk = 0, rst_n = 0;
  logic start = 0, s_valid = 0, s_last = 0, init = 0, done = 0;
  logic [15:0] s_data = '0;
  logic s_ready, prog_n, sel_n, wr_n, cclk, busy, ok, err;
  logic [15:0] d;

  logic start4 = 0;
  logic s_ready4, prog_n4, sel_n4, wr_n4, cclk4, busy4, ok4, err4;
  logic [31:0] d4;

  int checks = 0, fails = 0;
  int rises = 0, falls = 0;
  logic [15:0] got [0:255];

  always #5 clk = ~clk;

  cfg_loader #(.BUS_BYTES(2), .RST_CYCLES(RSTC), .DONE_TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .s_data(s_data), .s_valid(s_valid),
    .s_last(s_last), .s_ready(s_ready), .cfg_prog_n(prog_n), .cfg_sel_n(sel_n),
    .cfg_wr_n(wr_n), .cfg_cclk(cclk), .cfg_d(d), .cfg_init(init), .cfg_done(done),
    .busy(busy), .ok(ok), .err(err));

  cfg_loader #(.BUS_BYTES(4), .RST_CYCLES(RSTC), .DONE_TIMEOUT(TMO)) dut_w4 (
    .clk(clk), .rst_n(rst_n), .start(start4), .s_data(32'h0), .s_valid(1'b1),
    .s_last(1'b1), .s_ready(s_ready4), .cfg_prog_n(prog_n4), .cfg_sel_n(sel_n4),
    .cfg_wr_n(wr_n4), .cfg_cclk(cclk4), .cfg_d(d4), .cfg_init(1'b1), .cfg_done(1'b1),
    .busy(busy4), .ok(ok4), .err(err4));

  always @(posedge cclk) begin
    got[rises[7:0]] = d;
    rises = rises + 1;
  end
  always @(negedge prog_n) falls = falls + 1;

  task automatic chk(input bit c, input string req, input string what, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic prologue(input bit look);
    int lows = 0;
    int r0;
    init = 0; done = 0;
    kick();
    if (look) begin
      chk(busy && prog_n && !sel_n && !wr_n, "R2", "setup cycle pins", {busy,prog_n,sel_n,wr_n}, 4'b1100);
      chk(!ok && !err, "R10", "flags during load", {ok,err}, 0);
    end
    while (prog_n) @(negedge clk);
    while (!prog_n) begin lows++; @(negedge clk); end
    if (look) chk(lows == RSTC, "R2", "reset pulse length", lows, RSTC);
    r0 = rises;
    for (int i = 0; i < 10; i++) begin
      if (look && s_ready) chk(0, "R3", "ready before init", 1, 0);
      @(negedge clk);
    end
    if (look) chk(!s_ready && rises == r0, "R3", "no transfer before init", rises - r0, 0);
    init = 1;
  endtask

  task automatic send(input int n, input int base, input bit drop_init, input bit kick_mid);
    for (int i = 0; i < n; i++) begin
      if (i % 3 == 2) begin s_valid = 0; @(negedge clk); end
      s_valid = 1; s_data = 16'(base + i * 16'h0111); s_last = (i == n - 1);
      if (drop_init && i == n - 1) init = 0;
      while (!s_ready) @(negedge clk);
      if (kick_mid && i == 1) start = 1;
      @(negedge clk);
      start = 0;
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 2000) begin g++; @(negedge clk); end
  endtask

  task automatic t_reset_state();
    chk(prog_n && sel_n && wr_n && !cclk && !s_ready, "R1", "idle pins", {prog_n,sel_n,wr_n,cclk,s_ready}, 5'b11100);
    chk(!busy && !ok && !err, "R1", "idle status", {busy,ok,err}, 0);
  endtask

  task automatic t_good_load(input int n, input int base, input bit kick_mid);
    int r0, f0, bad = 0;
    f0 = falls;
    prologue(1);
    r0 = rises;
    send(n, base, 0, kick_mid);
    repeat (6) @(negedge clk);
    done = 1;
    wait_idle();
    chk(rises - r0 == n + 8, "R7", "cclk pulses incl. 8 trailing", rises - r0, n + 8);
    for (int i = 0; i < n; i++)
      if (got[8'(r0 + i)] != 16'(base + i * 16'h0111)) bad++;
    chk(bad == 0, "R4", "words in order", bad, 0);
    chk(ok && !err, "R7", "ok after done", {ok,err}, 2);
    if (kick_mid) chk(falls - f0 == 1, "R9", "start while busy ignored", falls - f0, 1);
  endtask

  task automatic t_init_error();
    int r0;
    prologue(0);
    r0 = rises;
    send(4, 16'h1000, 1, 0);
    wait_idle();
    chk(err && !ok, "R5", "init low after data -> err", {ok,err}, 1);
    chk(rises - r0 == 4, "R5", "no trailing clocks", rises - r0, 4);
  endtask

  task automatic t_done_timeout();
    int r0, cyc = 0;
    prologue(0);
    r0 = rises;
    send(3, 16'h2000, 0, 0);
    while (rises - r0 < 3) @(negedge clk);
    while (busy && cyc < 2000) begin cyc++; @(negedge clk); end
    chk(cyc == TMO + 1, "R6", "timeout window", cyc, TMO + 1);
    chk(err && !ok, "R6", "timeout -> err", {ok,err}, 1);
    repeat (5) @(negedge clk);
    chk(rises - r0 == 3, "R6", "no trailing clocks", rises - r0, 3);
  endtask

  task automatic t_bad_width();
    int moved = 0;
    @(negedge clk) start4 = 1;
    @(negedge clk) start4 = 0;
    for (int i = 0; i < 10; i++) begin
      if (!prog_n4 || !sel_n4 || !wr_n4 || cclk4 || s_ready4) moved++;
      @(negedge clk);
    end
    chk(err4 && !ok4 && !busy4, "R8", "unsupported width rejected", {busy4,ok4,err4}, 1);
    chk(moved == 0, "R8", "no pin activity", moved, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_good_load(5, 16'hA000, 0);
    t_init_error();
    t_done_timeout();
    t_good_load(4, 16'h5A00, 1);
    chk(!err, "R10", "err cleared by new start", err, 0);
    t_bad_width();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule